// File: doc/BRIEF.md
# Tournament Branch Direction Predictor

This block predicts whether a conditional branch is taken. It runs two correlating predictors side by side. The per-branch predictor uses the branch address to pick a history of that branch's recent outcomes, and that history selects a 2-bit saturating counter. The path-wide predictor uses one shift register of recent outcomes from all branches to select a counter in a second table. A third table of 2-bit counters, indexed by branch address, learns for each branch which of the two predictors to follow.

A fetch stage presents a branch address on the lookup port. Within the same cycle it receives the final direction, both component directions, the chooser decision and the two history values that were used. When the branch resolves, the pipeline returns the address, the actual outcome and the two captured histories on the update port. The tables and history registers then change at the next clock edge.

Top module: `tournament_predictor`

## Requirements
- R1: After reset every counter in all three tables holds 1 (weakly not-taken), and every history is zero. Any lookup then returns not-taken from both components, selects the per-branch component, and reports zero histories.
- R2: The per-branch history is the entry selected by address bits [2 +: LI_W]. The per-branch prediction is taken when the counter selected by that history holds 2 or 3.
- R3: The path-wide prediction is taken when the counter selected by the global history register holds 2 or 3.
- R4: The final direction equals the path-wide prediction when the chooser counter selected by address bits [2 +: GH_W] holds 2 or 3, and equals the per-branch prediction otherwise. When the two components agree, the final direction equals both.
- R5: On an update, the per-branch counter at the returned per-branch history and the path-wide counter at the returned global history each step up by one if taken and down by one if not-taken. Neither goes above 3 or below 0.
- R6: The chooser counter for the updated address changes only when the two components disagree, as read from the counters at the returned histories. It steps toward 3 if the path-wide component was right and toward 0 if the per-branch component was right.
- R7: On an update, the per-branch history entry for the update address shifts left and takes the outcome into bit 0 (1 = taken).
- R8: On each update, the global history register shifts left and takes the outcome into bit 0.
- R9: A lookup is combinational. When an update occurs in the same cycle, the lookup reflects the state from before that update.
- R10: While upd_valid is low, no table or history changes, whatever the other update inputs carry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| lkp_pc | input | PC_W | Branch address to predict |
| pred_taken | output | 1 | Final direction (1 = taken) |
| pred_local | output | 1 | Per-branch component direction |
| pred_global | output | 1 | Path-wide component direction |
| pred_use_global | output | 1 | Chooser selects path-wide component |
| lkp_lhist | output | LH_W | Per-branch history used for this lookup |
| lkp_ghist | output | GH_W | Global history used for this lookup |
| upd_valid | input | 1 | Apply an update this cycle |
| upd_pc | input | PC_W | Address of the resolved branch |
| upd_taken | input | 1 | Resolved outcome (1 = taken) |
| upd_lhist | input | LH_W | Per-branch history captured at prediction |
| upd_ghist | input | GH_W | Global history captured at prediction |

## Verification
A wrong counter step or a missed saturation stays hidden until the same history value indexes that counter again. It then shows as a flipped pred_local or pred_global, often many updates later. A history shift error shows on lkp_lhist or lkp_ghist on the first lookup after the edge, so those outputs are compared on every lookup. A chooser trained at the wrong time shows only on pred_use_global for a branch whose components later disagree. For that reason the stimulus revisits a small set of addresses with repeating and random outcome patterns, while a reference model tracks every table.

// File: rtl/tp_pkg.sv
package tp_pkg;
    typedef logic [1:0] ctr_t;

    localparam ctr_t CTR_INIT = 2'd1;

    // saturating step toward 3 (up) or 0 (down)
    function automatic ctr_t ctr_step(input ctr_t c, input logic up);
        if (up) return (c == 2'd3) ? c : c + 2'd1;
        else    return (c == 2'd0) ? c : c - 2'd1;
    endfunction

    function automatic logic ctr_high(input ctr_t c);
        return c[1];
    endfunction
endpackage

// File: rtl/tp_ctr_table.sv
module tp_ctr_table
    import tp_pkg::*;
#(
    parameter int IDX_W = 10
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [IDX_W-1:0] rd_idx,
    output ctr_t             rd_val,
    input  logic [IDX_W-1:0] up_idx,
    output ctr_t             up_val,
    input  logic             up_en,
    input  logic             up_dir
);
    localparam int DEPTH = 1 << IDX_W;

    ctr_t tbl_q [DEPTH];
    ctr_t tbl_d [DEPTH];

    assign rd_val = tbl_q[rd_idx];
    assign up_val = tbl_q[up_idx];

    always_comb begin
        tbl_d = tbl_q;
        if (up_en) tbl_d[up_idx] = ctr_step(tbl_q[up_idx], up_dir);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) tbl_q <= '{default: CTR_INIT};
        else        tbl_q <= tbl_d;
    end
endmodule

// File: rtl/tp_hist_table.sv
module tp_hist_table #(
    parameter int IDX_W  = 10,
    parameter int HIST_W = 10
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [IDX_W-1:0]  rd_idx,
    output logic [HIST_W-1:0] rd_hist,
    input  logic              up_en,
    input  logic [IDX_W-1:0]  up_idx,
    input  logic              up_bit
);
    localparam int DEPTH = 1 << IDX_W;

    logic [HIST_W-1:0] hist_q [DEPTH];
    logic [HIST_W-1:0] hist_d [DEPTH];

    assign rd_hist = hist_q[rd_idx];

    always_comb begin
        hist_d = hist_q;
        if (up_en) hist_d[up_idx] = {hist_q[up_idx][HIST_W-2:0], up_bit};
    end

    always_ff @(posedge clk) begin
        if (!rst_n) hist_q <= '{default: '0};
        else        hist_q <= hist_d;
    end
endmodule

// File: rtl/tournament_predictor.sv
module tournament_predictor
    import tp_pkg::*;
#(
    parameter int PC_W = 32,
    parameter int LI_W = 10,  // log2 of per-branch history entries
    parameter int LH_W = 10,  // per-branch history bits
    parameter int GH_W = 10   // global history bits (also chooser index width)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [PC_W-1:0] lkp_pc,
    output logic            pred_taken,
    output logic            pred_local,
    output logic            pred_global,
    output logic            pred_use_global,
    output logic [LH_W-1:0] lkp_lhist,
    output logic [GH_W-1:0] lkp_ghist,
    input  logic            upd_valid,
    input  logic [PC_W-1:0] upd_pc,
    input  logic            upd_taken,
    input  logic [LH_W-1:0] upd_lhist,
    input  logic [GH_W-1:0] upd_ghist
);
    localparam int PC_LSB = 2;

    typedef struct packed {
        logic [GH_W-1:0] ghist;
    } top_state_t;

    top_state_t st_q, st_d;

    ctr_t lct_rd, lct_up, gct_rd, gct_up, cho_rd, cho_up;
    logic up_loc_pred, up_glb_pred, disagree;

    assign lkp_ghist = st_q.ghist;

    tp_hist_table #(.IDX_W(LI_W), .HIST_W(LH_W)) u_lht (
        .clk    (clk),
        .rst_n  (rst_n),
        .rd_idx (lkp_pc[PC_LSB +: LI_W]),
        .rd_hist(lkp_lhist),
        .up_en  (upd_valid),
        .up_idx (upd_pc[PC_LSB +: LI_W]),
        .up_bit (upd_taken)
    );

    tp_ctr_table #(.IDX_W(LH_W)) u_lct (
        .clk   (clk),
        .rst_n (rst_n),
        .rd_idx(lkp_lhist),
        .rd_val(lct_rd),
        .up_idx(upd_lhist),
        .up_val(lct_up),
        .up_en (upd_valid),
        .up_dir(upd_taken)
    );

    tp_ctr_table #(.IDX_W(GH_W)) u_gct (
        .clk   (clk),
        .rst_n (rst_n),
        .rd_idx(st_q.ghist),
        .rd_val(gct_rd),
        .up_idx(upd_ghist),
        .up_val(gct_up),
        .up_en (upd_valid),
        .up_dir(upd_taken)
    );

    assign up_loc_pred = ctr_high(lct_up);
    assign up_glb_pred = ctr_high(gct_up);
    assign disagree    = up_loc_pred ^ up_glb_pred;

    tp_ctr_table #(.IDX_W(GH_W)) u_cho (
        .clk   (clk),
        .rst_n (rst_n),
        .rd_idx(lkp_pc[PC_LSB +: GH_W]),
        .rd_val(cho_rd),
        .up_idx(upd_pc[PC_LSB +: GH_W]),
        .up_val(cho_up),
        .up_en (upd_valid && disagree),
        .up_dir(up_glb_pred == upd_taken)
    );

    always_comb begin
        pred_local      = ctr_high(lct_rd);
        pred_global     = ctr_high(gct_rd);
        pred_use_global = ctr_high(cho_rd);
        pred_taken      = pred_use_global ? pred_global : pred_local;
    end

    always_comb begin
        st_d = st_q;
        if (upd_valid) st_d.ghist = {st_q.ghist[GH_W-2:0], upd_taken};
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end
endmodule

// File: rtl/tp_checker.sv
module tp_checker #(
    parameter int GH_W = 10
) (
    input logic            clk,
    input logic            rst_n,
    input logic            upd_valid,
    input logic            upd_taken,
    input logic [GH_W-1:0] lkp_ghist,
    input logic            pred_taken,
    input logic            pred_local,
    input logic            pred_global
);
    // R8
    ghist_shift_chk: assert property (@(posedge clk) disable iff (!rst_n)
        upd_valid |=> lkp_ghist == {$past(lkp_ghist[GH_W-2:0]), $past(upd_taken)});

    // R10
    ghist_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !upd_valid |=> $stable(lkp_ghist));

    // R4
    final_is_component_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pred_taken == pred_local) || (pred_taken == pred_global));

    // R4
    agree_passthru_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pred_local == pred_global) |-> (pred_taken == pred_local));
endmodule

bind tournament_predictor tp_checker #(.GH_W(GH_W)) u_tp_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .upd_valid  (upd_valid),
    .upd_taken  (upd_taken),
    .lkp_ghist  (lkp_ghist),
    .pred_taken (pred_taken),
    .pred_local (pred_local),
    .pred_global(pred_global)
);

// File: tb/tournament_predictor_tb.sv
module tournament_predictor_tb;
    localparam int PC_W = 16;
    localparam int LI_W = 3;
    localparam int LH_W = 3;
    localparam int GH_W = 3;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic [PC_W-1:0] lkp_pc = '0;
    logic            pred_taken, pred_local, pred_global, pred_use_global;
    logic [LH_W-1:0] lkp_lhist;
    logic [GH_W-1:0] lkp_ghist;
    logic            upd_valid = 1'b0;
    logic [PC_W-1:0] upd_pc = '0;
    logic            upd_taken = 1'b0;
    logic [LH_W-1:0] upd_lhist = '0;
    logic [GH_W-1:0] upd_ghist = '0;

    always #2.5 clk = ~clk;

    tournament_predictor #(.PC_W(PC_W), .LI_W(LI_W), .LH_W(LH_W), .GH_W(GH_W)) u_dut (
        .clk(clk), .rst_n(rst_n), .lkp_pc(lkp_pc),
        .pred_taken(pred_taken), .pred_local(pred_local), .pred_global(pred_global),
        .pred_use_global(pred_use_global), .lkp_lhist(lkp_lhist), .lkp_ghist(lkp_ghist),
        .upd_valid(upd_valid), .upd_pc(upd_pc), .upd_taken(upd_taken),
        .upd_lhist(upd_lhist), .upd_ghist(upd_ghist)
    );

    typedef struct {
        logic            loc, glb, use_g, fin;
        logic [LH_W-1:0] lh;
        logic [GH_W-1:0] gh;
    } exp_t;

    exp_t exp_q[$];
    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    // reference model
    logic [LH_W-1:0] m_lht [1 << LI_W];
    logic [1:0]      m_lct [1 << LH_W];
    logic [1:0]      m_gct [1 << GH_W];
    logic [1:0]      m_cho [1 << GH_W];
    logic [GH_W-1:0] m_gh;

    function automatic logic [1:0] sat(input logic [1:0] c, input logic up);
        if (up) return (c == 2'd3) ? 2'd3 : c + 2'd1;
        return (c == 2'd0) ? 2'd0 : c - 2'd1;
    endfunction

    task automatic model_reset();
        foreach (m_lht[i]) m_lht[i] = '0;
        foreach (m_lct[i]) m_lct[i] = 2'd1;
        foreach (m_gct[i]) m_gct[i] = 2'd1;
        foreach (m_cho[i]) m_cho[i] = 2'd1;
        m_gh = '0;
    endtask

    task automatic chk(input string req, input string what, input int act, input int expv);
        checks++;
        if (act != expv) begin
            errors++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, expv);
        end
    endtask

    // driver: one lookup, optionally with an update of the same branch in the same cycle
    task automatic step(input logic [PC_W-1:0] pc, input logic do_upd, input logic tkn);
        exp_t e;
        logic [LI_W-1:0] li;
        logic [GH_W-1:0] ci;
        @(negedge clk);
        #1;
        li = pc[2 +: LI_W];
        ci = pc[2 +: GH_W];
        e.lh    = m_lht[li];
        e.gh    = m_gh;
        e.loc   = m_lct[e.lh][1];
        e.glb   = m_gct[e.gh][1];
        e.use_g = m_cho[ci][1];
        e.fin   = e.use_g ? e.glb : e.loc;
        lkp_pc  = pc;
        upd_valid = do_upd;
        upd_pc    = do_upd ? pc : PC_W'($urandom);
        upd_taken = do_upd ? tkn : 1'($urandom);   // R10: garbage while invalid
        upd_lhist = do_upd ? e.lh : LH_W'($urandom);
        upd_ghist = do_upd ? e.gh : GH_W'($urandom);
        exp_q.push_back(e);  // R9: expectation built from pre-update state
        @(posedge clk);
        #0.5;
        if (do_upd) begin
            if (e.loc != e.glb) m_cho[ci] = sat(m_cho[ci], e.glb == tkn);   // R6
            m_lct[e.lh] = sat(m_lct[e.lh], tkn);                              // R5
            m_gct[e.gh] = sat(m_gct[e.gh], tkn);
            m_lht[li]   = {m_lht[li][LH_W-2:0], tkn};                         // R7
            m_gh        = {m_gh[GH_W-2:0], tkn};                              // R8
        end
    endtask

    // monitor
    initial begin
        forever begin
            @(negedge clk);
            #2;
            if (exp_q.size() != 0) begin
                exp_t e;
                e = exp_q.pop_front();
                chk("R2_R7", "lkp_lhist", lkp_lhist, e.lh);
                chk("R8", "lkp_ghist", lkp_ghist, e.gh);
                chk("R2_R5", "pred_local", pred_local, e.loc);
                chk("R3_R5", "pred_global", pred_global, e.glb);
                chk("R6", "pred_use_global", pred_use_global, e.use_g);
                chk("R4_R9", "pred_taken", pred_taken, e.fin);
            end
        end
    end

    initial begin
        model_reset();
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        // R1: reset state at the ports
        @(negedge clk);
        #1;
        for (int p = 0; p < 4; p++) begin
            lkp_pc = PC_W'(p * 4);
            #0.2;
            chk("R1", "pred_taken", pred_taken, 0);
            chk("R1", "pred_use_global", pred_use_global, 0);
            chk("R1", "lkp_lhist", lkp_lhist, 0);
            chk("R1", "lkp_ghist", lkp_ghist, 0);
        end
        // always-taken branch: counters saturate high (R5)
        for (int i = 0; i < 10; i++) step(16'h0010, 1'b1, 1'b1);
        // always-not-taken branch: saturate low
        for (int i = 0; i < 10; i++) step(16'h0024, 1'b1, 1'b0);
        // alternating branch learned through its own history (R2, R7)
        for (int i = 0; i < 24; i++) step(16'h0008, 1'b1, 1'(i % 2));
        // interleaved branches, pattern T T N, to create disagreement (R6)
        for (int i = 0; i < 30; i++) begin
            step(16'h000c, 1'b1, (i % 3) != 2);
            step(16'h001c, 1'b1, (i % 2) == 0);
        end
        // R10: idle lookups with garbage on update inputs
        for (int i = 0; i < 8; i++) step(PC_W'(i * 4), 1'b0, 1'b1);
        // random mix
        for (int i = 0; i < 300; i++)
            step(PC_W'(($urandom % 16) * 4), 1'($urandom % 4 != 0), 1'($urandom));
        step(16'h0000, 1'b0, 1'b0);
        repeat (3) @(posedge clk);
        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        #(200000 * 5);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog expired actual=0 expected=1");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule